// File: doc/BRIEF.md
# Glitch-Free PWM Timer with Deferred Compare Update

This block is an 8-bit up-counting timer that drives a pulse-width-modulated output. A one-cycle count-enable tick from an external prescaler advances it. Each counter period lasts 256 ticks. The output is high from the start of a period until the counter reaches the active compare value. A one-cycle interrupt pulse marks every wrap of the counter.

Software writes a new compare value through a write port. That value does not reach the comparator at once. It first moves to a pending stage on the tick that takes the counter to its top value, and then to the active stage on the wrap tick. A period is therefore never cut short or stretched by a write. A write that arrives too late for the pending stage waits one more full period. The read port always returns the most recently written value, even while the older value still drives the output.

While the timer enable is low, the counter rests at zero and the output stays low. The pending and active stages also follow the write buffer directly, so the first period after enabling uses the latest written value.

Top module: `pwm_buffered_timer`

## Requirements
- R1: When `run_i` is high, the counter advances by one on each cycle with `tick_i` high and wraps from FFh to 00h. A period is exactly 256 ticks.
- R2: `ovf_irq_o` is high for exactly one clock, in the cycle in which the counter first shows 00h after a wrap. There is one pulse per period.
- R3: A write captured at a clock edge before the tick edge that moves the counter from FEh to FFh becomes active at the very next wrap.
- R4: A write captured on the FEh-to-FFh tick edge, or later in the period, leaves the old value active for one more full period. It becomes active at the second wrap.
- R5: From the cycle after a write, `rd_data_o` returns the written value, whatever the active value is.
- R6: While running, `pwm_o` is high while the counter is below the active compare value and low otherwise. Over one period the output is high for (active value × tick spacing) clocks. A compare value of 00h gives a constant low output, and FFh gives 255 high ticks.
- R7: While `run_i` is low, the counter holds 00h, `pwm_o` is low from the next cycle and no interrupt pulses occur. A value written while disabled becomes active directly.
- R8: After reset, `pwm_o` and `ovf_irq_o` are low, and both the read value and the active compare value are 00h.
- R9: The counter changes only in cycles with `tick_i` high. With a tick every third clock, a period is 768 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle count-enable tick |
| run_i | input | 1 | Timer enable; low holds the counter at zero |
| wr_en_i | input | 1 | Compare-value write strobe |
| wr_data_i | input | 8 | Compare value to write |
| rd_data_o | output | 8 | Last written compare value |
| pwm_o | output | 1 | PWM output |
| ovf_irq_o | output | 1 | One-cycle pulse at counter wrap |

## Verification
A wrong active compare value shows up as a changed count of high cycles within the first full period after the intended commit wrap. A pending stage sampled on the wrong tick shifts a boundary write (one captured on the FDh-to-FEh edge versus one captured on the FEh-to-FFh edge) by a whole period, which shows up one period late. A counter that is not held, or that wraps at the wrong value, moves the interrupt pulse away from its 256-tick spacing. This appears at the first expected pulse.

// File: rtl/pwmt_pkg.sv
// Shared types for the buffered PWM timer.
// Assumes: single clock domain; events are one-cycle qualified strobes.
package pwmt_pkg;

    // Counter events that drive the compare commit pipeline.
    typedef struct packed {
        logic to_top;  // this tick moves the counter to its top value
        logic wrap;    // this tick wraps the counter to zero
    } cnt_evt_t;

endpackage

// File: rtl/pwmt_counter.sv
// Up-counter for the PWM timer. It advances on each qualified tick, is held
// at zero while disabled, and raises a one-cycle overflow pulse on wrap.
// Assumes: tick_i is a one-cycle strobe; synchronous active-low reset.
module pwmt_counter
    import pwmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    output logic [W-1:0] cnt_o,
    output cnt_evt_t     evt_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] CNT_TOP = '1;
    localparam logic [W-1:0] CNT_PRE = CNT_TOP - {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic         ovf_q;
    logic         adv;

    // Decode the qualified advance and the events it produces.
    always_comb begin
        adv          = run_i && tick_i;
        evt_o.to_top = adv && (cnt_q == CNT_PRE);
        evt_o.wrap   = adv && (cnt_q == CNT_TOP);
    end

    // Count register: held at zero when disabled, else advance on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (adv)    cnt_q <= cnt_q + 1'b1;
    end

    // Overflow pulse, high in the cycle the counter shows zero after a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= evt_o.wrap;
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R1: a wrap tick returns the counter to zero.
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && cnt_q == CNT_TOP) |=> (cnt_q == '0));
    // R9: without a tick the count does not move.
    a_r9_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_q));
    // R7: disabled timer holds zero.
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i) |=> (cnt_q == '0));
    // R2: overflow pulse lasts one clock and shows a zero count.
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);
    a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));
endmodule

// File: rtl/pwmt_cmp_buf.sv
// Compare-value pipeline: write buffer, then a pending stage sampled on the
// tick to the top count, then an active stage loaded on the wrap tick. When
// disabled, both later stages follow the newest written value directly.
// Assumes: evt_i comes from the counter in the same clock domain.
module pwmt_cmp_buf
    import pwmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  cnt_evt_t     evt_i,
    output logic [W-1:0] rd_o,
    output logic [W-1:0] act_o
);
    logic [W-1:0] buf_q;
    logic [W-1:0] pend_q;
    logic [W-1:0] act_q;
    logic [W-1:0] newest;

    // Newest value known this cycle, including a write in flight.
    always_comb newest = wr_en_i ? wr_data_i : buf_q;

    // Write buffer: holds the last value the CPU wrote.
    always_ff @(posedge clk) begin
        if (!rst_n)       buf_q <= '0;
        else if (wr_en_i) buf_q <= wr_data_i;
    end

    // Pending stage: sampled from the buffer on the tick to the top count.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= '0;
        else if (!run_i)       pend_q <= newest;
        else if (evt_i.to_top) pend_q <= buf_q;
    end

    // Active stage: takes the pending value at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          act_q <= '0;
        else if (!run_i)     act_q <= newest;
        else if (evt_i.wrap) act_q <= pend_q;
    end

    assign rd_o  = buf_q;
    assign act_o = act_q;

    // R5: a write is visible on the read path in the next cycle.
    a_r5_read_back: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (rd_o == $past(wr_data_i)));
    // R3: while running, the active value moves only at a wrap.
    a_r3_active_only_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !evt_i.wrap) |=> $stable(act_q));
    // R4: while running, the pending value moves only on the top tick.
    a_r4_pending_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !evt_i.to_top) |=> $stable(pend_q));
endmodule

// File: rtl/pwmt_pwm_out.sv
// PWM output stage: high while the count is below the active compare value,
// forced low while the timer is disabled (via a registered enable).
// Assumes: cnt_i is held at zero while disabled.
module pwmt_pwm_out #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] act_i,
    output logic         pwm_o
);
    logic run_q;

    // Registered enable, aligned with the counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_i;
    end

    // Output comparison.
    always_comb pwm_o = run_q && (cnt_i < act_i);

    // R6: a zero compare value never drives the output high.
    a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == '0) |-> !pwm_o);
    // R7: after enable falls the output is low.
    a_r7_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pwm_o);
endmodule

// File: rtl/pwm_buffered_timer.sv
// Top of the buffered PWM timer: counter, compare pipeline and output stage.
// Assumes: tick_i comes from an external prescaler in the clk domain.
module pwm_buffered_timer
    import pwmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] rd_data_o,
    output logic         pwm_o,
    output logic         ovf_irq_o
);
    logic [W-1:0] cnt;
    logic [W-1:0] act;
    cnt_evt_t     evt;

    pwmt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .cnt_o(cnt), .evt_o(evt), .ovf_o(ovf_irq_o)
    );

    pwmt_cmp_buf #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .evt_i(evt), .rd_o(rd_data_o), .act_o(act)
    );

    pwmt_pwm_out #(.W(W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .cnt_i(cnt), .act_i(act),
        .pwm_o(pwm_o)
    );
endmodule

// File: tb/pwm_buffered_timer_bench.sv
module pwm_buffered_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       run_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       pwm_o;
    logic       ovf_irq_o;

    int n_chk = 0;
    int n_fail = 0;
    int tick_div = 1;
    int tick_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_buffered_timer u_pwm_buffered_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .pwm_o(pwm_o), .ovf_irq_o(ovf_irq_o)
    );

    // Tick generator: one tick every tick_div clocks.
    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_div) begin
            tick_cnt <= 0;
            tick_i   <= 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1;
            tick_i   <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_irq();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!ovf_irq_o && guard < 3000);
        check(ovf_irq_o, "R2 irq seen", ovf_irq_o, 1);
    endtask

    // Count high and irq cycles over n clocks starting at the current one.
    task automatic measure(input int n, output int hi, output int irqs);
        hi = 0;
        irqs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_o) hi++;
            if (ovf_irq_o) irqs++;
            @(negedge clk);
        end
    endtask

    task automatic write_val(input logic [7:0] v);
        wr_en_i   = 1'b1;
        wr_data_i = v;
        @(negedge clk);
        wr_en_i   = 1'b0;
        check(rd_data_o == v, "R5 read back", rd_data_o, v);
    endtask

    task automatic t_reset();
        int hi, irqs;
        repeat (3) @(negedge clk);
        check(!pwm_o, "R8 pwm low", pwm_o, 0);
        check(!ovf_irq_o, "R8 irq low", ovf_irq_o, 0);
        check(rd_data_o == 0, "R8 read zero", rd_data_o, 0);
        rst_n = 1'b1;
        run_i = 1'b1;
        wait_irq();
        measure(256, hi, irqs);
        check(hi == 0, "R8 active zero", hi, 0);
        check(irqs == 1, "R2 one pulse per period", irqs, 1);
        check(ovf_irq_o, "R1 period 256 ticks", ovf_irq_o, 1);
    endtask

    task automatic t_early();
        int hi, irqs;
        wait_irq();
        repeat (253) @(negedge clk);   // counter at FDh
        write_val(8'h90);              // captured on FDh->FEh edge
        wait_irq();
        measure(256, hi, irqs);
        check(hi == 'h90, "R3 early write active next wrap", hi, 'h90);
        check(irqs == 1, "R2 single pulse", irqs, 1);
    endtask

    task automatic t_late();
        int hi, irqs;
        wait_irq();
        repeat (254) @(negedge clk);   // counter at FEh
        write_val(8'h20);              // captured on FEh->FFh edge
        check(rd_data_o == 8'h20, "R5 read newest while old active", rd_data_o, 'h20);
        wait_irq();
        measure(256, hi, irqs);
        check(hi == 'h90, "R4 old value kept one period", hi, 'h90);
        measure(256, hi, irqs);
        check(hi == 'h20, "R4 new value at second wrap", hi, 'h20);
    endtask

    task automatic t_extremes();
        int hi, irqs;
        wait_irq();
        repeat (100) @(negedge clk);
        write_val(8'h00);
        wait_irq();
        measure(256, hi, irqs);
        check(hi == 0, "R6 zero compare constant low", hi, 0);
        check(irqs == 1, "R2 pulse with zero compare", irqs, 1);
        repeat (100) @(negedge clk);
        write_val(8'hFF);
        wait_irq();
        measure(256, hi, irqs);
        check(hi == 255, "R6 FFh compare", hi, 255);
    endtask

    task automatic t_slow();
        int hi, irqs;
        tick_div = 3;
        wait_irq();
        wait_irq();
        measure(768, hi, irqs);
        check(hi == 765, "R9 high cycles scale with tick", hi, 765);
        check(irqs == 1, "R9 one pulse per 768 clocks", irqs, 1);
        check(ovf_irq_o, "R9 period 768 clocks", ovf_irq_o, 1);
        tick_div = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_disable();
        int hi, irqs;
        run_i = 1'b0;
        @(negedge clk);
        check(!pwm_o, "R7 low next cycle", pwm_o, 0);
        measure(300, hi, irqs);
        check(hi == 0, "R7 no pwm while off", hi, 0);
        check(irqs == 0, "R7 no irq while off", irqs, 0);
        write_val(8'h10);
        run_i = 1'b1;
        wait_irq();
        measure(256, hi, irqs);
        check(hi == 'h10, "R7 idle write used at start", hi, 'h10);
    endtask

    initial begin
        t_reset();
        t_early();
        t_late();
        t_extremes();
        t_slow();
        t_disable();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule